// File: doc/BRIEF.md
# Store Queue with Load Forwarding

The block keeps stores that are still in flight in the order the program issued them. Each store moves through the same steps. It is allocated a slot at dispatch. It later executes and supplies its address, size and data. It retires, and finally it is written out to memory through a drain handshake. A load presents its address, its size and an age tag. The block then decides whether the load can take its bytes straight from an older store, must wait, or may read the cache.

The age tag is a ring position with a phase bit, so it counts `0 .. 2*DEPTH-1` and wraps. A load uses as its age the allocation tag that the next store would have received when the load was dispatched. Every slot holding a smaller tag, counted from the oldest live slot, is older than the load.

Each slot is a four-state machine:

| State | Meaning |
|-------|---------|
| `SLOT_FREE` | The slot is empty. |
| `SLOT_PEND` | The store is allocated but its address is not yet known. |
| `SLOT_DONE` | The store has executed. |
| `SLOT_RET` | The store has retired and waits to drain. |

The slot transitions are:

| Transition | Event |
|------------|-------|
| `SLOT_FREE`→`SLOT_PEND` | allocate |
| `SLOT_PEND`→`SLOT_DONE` | execute |
| `SLOT_DONE`→`SLOT_RET` | retire |
| `SLOT_RET`→`SLOT_FREE` | drain handshake |

The load outcome is held in a response register with four states:

| State | Meaning |
|-------|---------|
| `RSP_IDLE` | No query was made in the previous cycle. |
| `RSP_MISS` | No older store is relevant, so the load reads the cache. |
| `RSP_FWD` | Data is forwarded from an older store. |
| `RSP_HOLD` | The load must block. |

The response register is reloaded every cycle from the query of the previous cycle.

Top module: `store_fwd_buffer`

## Requirements
- R1: The buffer holds DEPTH (default 24) stores. `alloc_ready` is low exactly when all DEPTH slots are occupied, and an allocation attempted while it is low changes nothing.
- R2: Allocation tags are handed out in program order, starting at 0 after reset. Each tag is one more than the previous one, and the tag after 2*DEPTH-1 is 0.
- R3: Only stores older than the load are considered. A store whose tag is at or after the load's age has no effect on the load's outcome.
- R4: A load is forwarded (`ld_hit`=1, `ld_block`=0) when the deciding store has executed, has the same start address as the load, and covers at least as many bytes as the load. `ld_data` then holds the store's low bytes in its low bytes, masked to the load size. The size encoding is 0=1, 1=2, 2=4 and 3=8 bytes.
- R5: A store whose bytes span a 64-byte line boundary, so that (address mod 64) + bytes > 64, never forwards. A load that this store decides is blocked.
- R6: An executed older store that overlaps the load but has a different start address, or fewer bytes than the load, blocks the load (`ld_block`=1, `ld_hit`=0).
- R7: An older store that has not yet executed blocks the load when it is the deciding store.
- R8: The deciding store is the youngest older store that either has not executed or overlaps the load's bytes.
- R9: When no older store is relevant, the response is valid with both `ld_hit` and `ld_block` low, and the load reads the cache.
- R10: The `dr_*` outputs present the oldest slot only after it has retired. Stores leave strictly in program order, and a slot is freed only on the cycle when `dr_valid` and `dr_ready` are both high. While `dr_ready` is low, the outputs hold steady.
- R11: A query made in cycle t produces `ld_resp_valid` and its outcome in cycle t+1 only, and the query sees the buffer state as it was before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate a new store |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | TAG_W | Tag given to the next allocated store |
| exec_valid | input | 1 | Execute strobe for a store |
| exec_tag | input | TAG_W | Tag of the executing store |
| exec_addr | input | ADDR_W | Store byte address |
| exec_size | input | 2 | Store size code |
| exec_data | input | 64 | Store data, right-aligned |
| retire_valid | input | 1 | Retire the oldest unretired store |
| ld_valid | input | 1 | Load query strobe |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_age | input | TAG_W | First store tag younger than the load |
| ld_resp_valid | output | 1 | Response to the previous cycle's query |
| ld_hit | output | 1 | Data forwarded |
| ld_block | output | 1 | Load must wait |
| ld_data | output | 64 | Forwarded bytes, right-aligned |
| dr_valid | output | 1 | Oldest store is retired and ready to write |
| dr_ready | input | 1 | Memory accepts the drained store |
| dr_addr | output | ADDR_W | Drained store address |
| dr_size | output | 2 | Drained store size code |
| dr_data | output | 64 | Drained store data |

## Verification
`alloc_ready`, `alloc_tag` and the `dr_*` outputs come straight from registered state. They are due in the same cycle as the last edge that changed them, so the bench compares them before each rising edge against its queue model. The load outcome is due one edge after the query. The bench therefore computes the expected outcome from the model before that edge, so the model does not yet include that cycle's executes, allocations or drains, and compares it after the edge. Every other model update is applied just after each rising edge, which keeps both comparisons tied to the edge that produces the result.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_DONE = 2'd2,
        SLOT_RET  = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_MISS = 2'd1,
        RSP_FWD  = 2'd2,
        RSP_HOLD = 2'd3
    } rsp_st_e;

    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    function automatic logic [63:0] size_mask(input logic [1:0] code);
        logic [63:0] m;
        unique case (code)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sbf_slot.sv
module sbf_slot #(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic                exec_en,
    input  logic [ADDR_W-1:0]   exec_addr,
    input  logic [1:0]          exec_size,
    input  logic [63:0]         exec_data,
    input  logic                retire_en,
    input  logic                drain_en,
    output sbf_pkg::slot_st_e   st,
    output logic [ADDR_W-1:0]   addr,
    output logic [1:0]          size,
    output logic [63:0]         data
);
    import sbf_pkg::*;

    slot_st_e st_q, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SLOT_FREE: if (alloc_en)  st_nx = SLOT_PEND;
            SLOT_PEND: if (exec_en)   st_nx = SLOT_DONE;
            SLOT_DONE: if (retire_en) st_nx = SLOT_RET;
            SLOT_RET:  if (drain_en)  st_nx = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            size <= '0;
            data <= '0;
        end else if (exec_en && st_q == SLOT_PEND) begin
            addr <= exec_addr;
            size <= exec_size;
            data <= exec_data;
        end
    end

    assign st = st_q;

    // a slot is only allocated when it is free: no overwrite of a live store
    assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> st_q == SLOT_FREE);
    // execution fills only a slot still waiting for its address
    assert_exec_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |-> st_q == SLOT_PEND);
    // retirement follows execution
    assert_retire_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retire_en |-> st_q == SLOT_DONE);
    // only a retired store is written out, and it is gone on the next cycle
    assert_drain_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drain_en |=> st_q == SLOT_FREE);

endmodule

// File: rtl/sbf_cmp.sv
module sbf_cmp #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int LOFF_W    = $clog2(LINE_BYTES)
) (
    input  sbf_pkg::slot_st_e  st,
    input  logic               older,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [1:0]         s_size,
    input  logic [ADDR_W-1:0]  l_addr,
    input  logic [1:0]         l_size,
    output logic               relevant,
    output logic               fwd_ok
);
    import sbf_pkg::*;

    logic              executed;
    logic [ADDR_W:0]   s_end, l_end;
    logic              overlap;
    logic [LOFF_W+4:0] line_end;
    logic              crosses;

    always_comb begin
        executed = (st == SLOT_DONE) || (st == SLOT_RET);
        s_end    = {1'b0, s_addr} + (ADDR_W+1)'(size_bytes(s_size));
        l_end    = {1'b0, l_addr} + (ADDR_W+1)'(size_bytes(l_size));
        overlap  = ({1'b0, s_addr} < l_end) && ({1'b0, l_addr} < s_end);
        line_end = (LOFF_W+5)'(s_addr[LOFF_W-1:0]) + (LOFF_W+5)'(size_bytes(s_size));
        crosses  = line_end > (LOFF_W+5)'(LINE_BYTES);
        relevant = older && ((st == SLOT_PEND) || (executed && overlap));
        fwd_ok   = executed && (s_addr == l_addr) && (l_size <= s_size) && !crosses;
    end

endmodule

// File: rtl/sbf_pick.sv
module sbf_pick #(
    parameter int DEPTH  = 24,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head_idx,
    input  logic [DEPTH-1:0] rel,
    input  logic [DEPTH-1:0] fwd,
    output logic             any,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_fwd
);
    always_comb begin
        any     = 1'b0;
        sel_idx = '0;
        sel_fwd = 1'b0;
        // walk from oldest to youngest; the last relevant slot wins
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s = int'(head_idx) + k;
            if (s >= DEPTH) s = s - DEPTH;
            if (rel[s]) begin
                any     = 1'b1;
                sel_idx = IDX_W'(s);
                sel_fwd = fwd[s];
            end
        end
    end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
    parameter int DEPTH      = 24,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int TAG_W     = $clog2(2*DEPTH),
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              exec_valid,
    input  logic [TAG_W-1:0]  exec_tag,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [1:0]        exec_size,
    input  logic [63:0]       exec_data,
    input  logic              retire_valid,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [TAG_W-1:0]  ld_age,
    output logic              ld_resp_valid,
    output logic              ld_hit,
    output logic              ld_block,
    output logic [63:0]       ld_data,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [1:0]        dr_size,
    output logic [63:0]       dr_data
);
    import sbf_pkg::*;

    localparam int NTAG = 2*DEPTH;

    function automatic logic [TAG_W-1:0] tag_next(input logic [TAG_W-1:0] t);
        return (int'(t) == NTAG-1) ? '0 : t + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] tag_idx(input logic [TAG_W-1:0] t);
        return (int'(t) >= DEPTH) ? IDX_W'(int'(t) - DEPTH) : IDX_W'(t);
    endfunction

    logic [TAG_W-1:0] head_q, tail_q, rptr_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] head_idx, tail_idx, rptr_idx, exec_idx;
    logic             alloc_fire, drain_fire;

    slot_st_e          slot_st   [DEPTH];
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [1:0]        slot_size [DEPTH];
    logic [63:0]       slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_older, slot_rel, slot_fwd;

    assign head_idx   = tag_idx(head_q);
    assign tail_idx   = tag_idx(tail_q);
    assign rptr_idx   = tag_idx(rptr_q);
    assign exec_idx   = tag_idx(exec_tag);
    assign alloc_ready = (int'(count_q) < DEPTH);
    assign alloc_tag  = tail_q;
    assign alloc_fire = alloc_valid && alloc_ready;
    assign dr_valid   = (slot_st[head_idx] == SLOT_RET);
    assign drain_fire = dr_valid && dr_ready;
    assign dr_addr    = slot_addr[head_idx];
    assign dr_size    = slot_size[head_idx];
    assign dr_data    = slot_data[head_idx];

    // ring pointers: allocation, retirement and drain all advance in order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_fire)   tail_q <= tag_next(tail_q);
            if (retire_valid) rptr_q <= tag_next(rptr_q);
            if (drain_fire)   head_q <= tag_next(head_q);
            count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(drain_fire);
        end
    end

    // which live slots precede the load in program order
    always_comb begin
        int d;
        logic ok;
        d = int'(ld_age) - int'(head_q);
        if (d < 0) d = d + NTAG;
        ok = (d <= int'(count_q));
        for (int i = 0; i < DEPTH; i++) begin
            int k;
            k = i - int'(head_idx);
            if (k < 0) k = k + DEPTH;
            slot_older[i] = ok && (k < d);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sbf_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (alloc_fire && tail_idx == IDX_W'(g)),
            .exec_en   (exec_valid && exec_idx == IDX_W'(g)),
            .exec_addr (exec_addr),
            .exec_size (exec_size),
            .exec_data (exec_data),
            .retire_en (retire_valid && rptr_idx == IDX_W'(g)),
            .drain_en  (drain_fire && head_idx == IDX_W'(g)),
            .st        (slot_st[g]),
            .addr      (slot_addr[g]),
            .size      (slot_size[g]),
            .data      (slot_data[g])
        );

        sbf_cmp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cmp (
            .st       (slot_st[g]),
            .older    (slot_older[g]),
            .s_addr   (slot_addr[g]),
            .s_size   (slot_size[g]),
            .l_addr   (ld_addr),
            .l_size   (ld_size),
            .relevant (slot_rel[g]),
            .fwd_ok   (slot_fwd[g])
        );
    end

    logic             pick_any, pick_fwd;
    logic [IDX_W-1:0] pick_idx;

    sbf_pick #(.DEPTH(DEPTH)) u_pick (
        .head_idx (head_idx),
        .rel      (slot_rel),
        .fwd      (slot_fwd),
        .any      (pick_any),
        .sel_idx  (pick_idx),
        .sel_fwd  (pick_fwd)
    );

    // response state machine
    rsp_st_e     rsp_q, rsp_nx;
    logic [63:0] rsp_data_q, rsp_data_nx;

    always_comb begin
        rsp_data_nx = '0;
        if (!ld_valid)      rsp_nx = RSP_IDLE;
        else if (!pick_any) rsp_nx = RSP_MISS;
        else if (pick_fwd)  rsp_nx = RSP_FWD;
        else                rsp_nx = RSP_HOLD;
        if (rsp_nx == RSP_FWD) rsp_data_nx = slot_data[pick_idx] & size_mask(ld_size);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= RSP_IDLE;
            rsp_data_q <= '0;
        end else begin
            rsp_q      <= rsp_nx;
            rsp_data_q <= rsp_data_nx;
        end
    end

    always_comb begin
        ld_resp_valid = 1'b1;
        ld_hit        = 1'b0;
        ld_block      = 1'b0;
        ld_data       = '0;
        unique case (rsp_q)
            RSP_IDLE: ld_resp_valid = 1'b0;
            RSP_MISS: ;
            RSP_FWD: begin
                ld_hit  = 1'b1;
                ld_data = rsp_data_q;
            end
            RSP_HOLD: ld_block = 1'b1;
        endcase
    end

    // a full buffer means the tail slot is still occupied
    assert_full_tail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |-> slot_st[tail_idx] != SLOT_FREE);
    // a stalled drain keeps offering the same store
    assert_drain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data));
    // a response exists only for a query one cycle earlier
    assert_resp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_resp_valid |-> $past(ld_valid));
    // forward and block never coexist
    assert_hit_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_block));

endmodule

// File: tb/store_fwd_buffer_tb.sv
`timescale 1ns/1ps
module store_fwd_buffer_tb;
    localparam int DEPTH = 24;
    localparam int TW    = 6;
    localparam int NT    = 2*DEPTH;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, alloc_valid, alloc_ready, exec_valid, retire_valid, ld_valid;
    logic ld_resp_valid, ld_hit, ld_block, dr_valid, dr_ready;
    logic [TW-1:0] alloc_tag, exec_tag, ld_age;
    logic [31:0] exec_addr, ld_addr, dr_addr;
    logic [1:0]  exec_size, ld_size, dr_size;
    logic [63:0] exec_data, ld_data, dr_data;

    store_fwd_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr),
        .exec_size(exec_size), .exec_data(exec_data), .retire_valid(retire_valid),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_age(ld_age),
        .ld_resp_valid(ld_resp_valid), .ld_hit(ld_hit), .ld_block(ld_block), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
        .dr_size(dr_size), .dr_data(dr_data)
    );

    typedef struct {
        int seq; bit ex; bit rt;
        logic [31:0] a; logic [1:0] s; logic [63:0] d;
    } mst_t;

    mst_t q[$];
    int next_seq = 0;
    int errors = 0;
    int checks = 0;
    int cur_lseq = 0;

    function automatic logic [63:0] msk(input logic [1:0] s);
        return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // kind: 0 read cache, 1 forward, 2 block
    task automatic model_load(input logic [31:0] la, input logic [1:0] ls, input int lseq,
                              output int kind, output logic [63:0] dat);
        kind = 0;
        dat  = '0;
        foreach (q[i]) begin
            if (q[i].seq < lseq) begin
                if (!q[i].ex) begin
                    kind = 2;
                end else begin
                    longint sa, sb, l0, lb;
                    sa = longint'(q[i].a); sb = longint'(1) << q[i].s;
                    l0 = longint'(la);     lb = longint'(1) << ls;
                    if (sa < l0 + lb && l0 < sa + sb) begin
                        if (sa == l0 && lb <= sb && (sa % 64) + sb <= 64) begin
                            kind = 1;
                            dat  = q[i].d & msk(ls);
                        end else begin
                            kind = 2;
                            dat  = '0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic tick(input string req);
        int k;
        logic [63:0] d;
        bit had, exp_dv, pre_room;
        k = 0; d = '0;
        chk(alloc_ready === (q.size() < DEPTH), "R1 alloc_ready", 64'(alloc_ready), 64'(q.size() < DEPTH));
        chk(alloc_tag === TW'(next_seq % NT), "R2 alloc_tag", 64'(alloc_tag), 64'(next_seq % NT));
        exp_dv = (q.size() > 0) && q[0].rt;
        chk(dr_valid === exp_dv, "R10 dr_valid", 64'(dr_valid), 64'(exp_dv));
        if (exp_dv) begin
            chk(dr_addr === q[0].a, "R10 dr_addr order", 64'(dr_addr), 64'(q[0].a));
            chk(dr_data === q[0].d, "R10 dr_data order", dr_data, q[0].d);
            chk(dr_size === q[0].s, "R10 dr_size", 64'(dr_size), 64'(q[0].s));
        end
        had = ld_valid;
        if (had) model_load(ld_addr, ld_size, cur_lseq, k, d);
        pre_room = q.size() < DEPTH;
        @(posedge clk);
        #1;
        if (exec_valid) begin
            foreach (q[i]) if (TW'(q[i].seq % NT) == exec_tag) begin
                q[i].ex = 1'b1; q[i].a = exec_addr; q[i].s = exec_size; q[i].d = exec_data;
            end
        end
        if (retire_valid) begin
            foreach (q[i]) if (!q[i].rt) begin q[i].rt = 1'b1; break; end
        end
        if (exp_dv && dr_ready) void'(q.pop_front());
        if (alloc_valid && pre_room) begin
            mst_t e;
            e.seq = next_seq; e.ex = 0; e.rt = 0; e.a = '0; e.s = '0; e.d = '0;
            q.push_back(e);
            next_seq++;
        end
        @(negedge clk);
        alloc_valid = 0; exec_valid = 0; retire_valid = 0; ld_valid = 0;
        chk(ld_resp_valid === had, {"R11 resp_valid ", req}, 64'(ld_resp_valid), 64'(had));
        if (had) begin
            chk(ld_hit === (k == 1), {"hit ", req}, 64'(ld_hit), 64'(k == 1));
            chk(ld_block === (k == 2), {"block ", req}, 64'(ld_block), 64'(k == 2));
            if (k == 1) chk(ld_data === d, {"R4 data ", req}, ld_data, d);
        end
    endtask

    task automatic do_alloc(input string req);
        alloc_valid = 1;
        tick(req);
    endtask

    task automatic do_exec(input int seq, input logic [31:0] a, input logic [1:0] s, input logic [63:0] dd);
        exec_valid = 1; exec_tag = TW'(seq % NT); exec_addr = a; exec_size = s; exec_data = dd;
        tick("R4 exec");
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] s, input int lseq, input string req);
        ld_valid = 1; ld_addr = a; ld_size = s; ld_age = TW'(lseq % NT); cur_lseq = lseq;
        tick(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog expired act=0 exp=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; alloc_valid = 0; exec_valid = 0; retire_valid = 0; ld_valid = 0; dr_ready = 0;
        exec_tag = '0; exec_addr = '0; exec_size = '0; exec_data = '0;
        ld_addr = '0; ld_size = '0; ld_age = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(alloc_ready === 1'b1, "R1 reset ready", 64'(alloc_ready), 64'd1);
        chk(alloc_tag === '0, "R2 reset tag", 64'(alloc_tag), 64'd0);
        chk(dr_valid === 1'b0, "R10 reset drain", 64'(dr_valid), 64'd0);
        chk(ld_resp_valid === 1'b0, "R11 reset resp", 64'(ld_resp_valid), 64'd0);

        do_alloc("R2"); do_alloc("R2"); do_alloc("R2");
        do_load(32'h100, 2'd3, 3, "R7 unexecuted older");
        do_exec(0, 32'h100, 2'd3, 64'h8877_6655_4433_2211);
        do_exec(1, 32'h200, 2'd2, 64'h1234_5678_DDCC_BBAA);
        do_exec(2, 32'h100, 2'd1, 64'hFFFF_FFFF_FFFF_F0E1);
        do_load(32'h100, 2'd0, 3, "R8 youngest older");
        do_load(32'h100, 2'd3, 3, "R6 store smaller");
        do_load(32'h100, 2'd3, 2, "R3 age excludes younger");
        do_load(32'h104, 2'd2, 1, "R6 unequal address");
        do_load(32'h300, 2'd3, 3, "R9 no overlap");
        do_load(32'h200, 2'd2, 1, "R3 younger ignored");
        do_load(32'h200, 2'd1, 3, "R4 contained forward");
        do_alloc("R2");
        do_exec(3, 32'h13C, 2'd3, 64'hA1A2_A3A4_A5A6_A7A8);
        do_load(32'h13C, 2'd2, 4, "R5 line crossing");
        do_load(32'h140, 2'd0, 4, "R5 crossing tail");
        do_alloc("R2");
        do_load(32'h500, 2'd0, 4, "R3 pending younger");
        do_load(32'h500, 2'd0, 5, "R7 pending older");
        retire_valid = 1; tick("R10 retire");
        retire_valid = 1; tick("R10 retire");
        dr_ready = 0; tick("R10 hold"); tick("R10 hold");
        dr_ready = 1; tick("R10 drain"); tick("R10 drain");
        dr_ready = 0;
        do_exec(4, 32'h500, 2'd0, 64'h77);

        while (q.size() < DEPTH) do_alloc("R1 fill");
        do_alloc("R1 full ignored");
        do_load(32'h500, 2'd0, next_seq, "R8 full buffer");

        for (int n = 0; n < 200 && q.size() > 0; n++) begin
            foreach (q[i]) if (!q[i].ex) begin
                exec_valid = 1; exec_tag = TW'(q[i].seq % NT);
                exec_addr = 32'h1000 + 32'(8 * i); exec_size = 2'd3;
                exec_data = 64'(q[i].seq) * 64'h0101_0101_0101_0101;
                break;
            end
            foreach (q[i]) if (!q[i].rt) begin
                if (q[i].ex) retire_valid = 1;
                break;
            end
            dr_ready = 1;
            tick("R10 flush");
        end

        for (int n = 0; n < 3000; n++) begin
            int lo;
            if ($urandom_range(0, 2) != 0) alloc_valid = 1;
            if ($urandom_range(0, 1) == 1) begin
                foreach (q[i]) if (!q[i].ex && $urandom_range(0, 2) == 0) begin
                    exec_valid = 1; exec_tag = TW'(q[i].seq % NT);
                    exec_addr = 32'h100 + 32'($urandom_range(0, 71));
                    exec_size = 2'($urandom_range(0, 3));
                    exec_data = {$urandom, $urandom};
                    break;
                end
            end
            foreach (q[i]) if (!q[i].rt) begin
                if (q[i].ex && $urandom_range(0, 1) == 1) retire_valid = 1;
                break;
            end
            dr_ready = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 1) == 1) begin
                lo = (q.size() > 0) ? q[0].seq : next_seq;
                ld_valid = 1;
                ld_addr = 32'h100 + 32'($urandom_range(0, 71));
                ld_size = 2'($urandom_range(0, 3));
                cur_lseq = $urandom_range(lo, next_seq);
                ld_age = TW'(cur_lseq % NT);
            end
            tick("R8 mixed");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule